// File: doc/BRIEF.md
# Double-Buffered Frame Base Address Registers

This block holds the frame-buffer start addresses that a display DMA engine fetches from: one address for the upper panel and one for the lower panel of a dual-panel screen (single-panel screens use only the upper one). Software writes pending addresses over a simple single-cycle register bus. The DMA engine sees only the current addresses, which are refreshed from the pending ones at a frame boundary, so it always fetches a whole frame from one stable address.

A transfer from pending to current happens on each rising edge of the vertical sync input while the controller enable is high. With the default parameter setting, it also happens on the cycle the enable rises. Each transfer sets a status flag. The flag means that both pending registers may be rewritten for the next frame, which is the basis of double-buffered video. The flag can drive an interrupt through a mask bit, and software clears it by writing one to a clear register.

Register offsets: upper pending 0x10, lower pending 0x14, interrupt mask 0x18, status 0x1C, flag clear 0x20, upper current 0x24, lower current 0x28.

Top module: `fbase_shadow_regs`

## Requirements
- R1: Synchronous active-high reset clears both pending registers, both current outputs, the mask, the status flag, `irq` and `bus_rdata` to zero.
- R2: The upper pending register is at offset 0x10 and the lower one at 0x14. Bits 31:2 are read/write. Bits 1:0 ignore written values and read as zero. A read strobe returns its data on `bus_rdata` after the next clock edge.
- R3: On the clock edge where `vsync` is first seen high while `ctrl_en` is high, both current outputs load their pending values. Holding `vsync` high over more cycles causes no further transfer.
- R4: Between transfers the current outputs stay unchanged, even when the pending registers are rewritten mid-frame. They can be read at 0x24 (upper) and 0x28 (lower), and bus writes to these offsets have no effect.
- R5: A `vsync` edge while `ctrl_en` is low causes no transfer and does not set the status flag.
- R6: With LOAD_ON_ENABLE=1 (the default), the clock edge where `ctrl_en` is first seen high performs a transfer.
- R7: Every transfer sets status bit 0 at 0x1C. The bit stays set until a write with bit 0 = 1 to offset 0x20. Offset 0x20 reads as zero.
- R8: `irq` equals the status flag ANDed with mask bit 0 at offset 0x18 (read/write), and it follows both on the same clock edge.
- R9: If a pending-register write and a transfer fall on the same edge, the current output takes the value held before the write. The new value is used at the next transfer.
- R10: If a flag clear and a transfer fall on the same edge, the flag ends up set.
- R11: Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Controller enable |
| vsync | input | 1 | Vertical sync level from the timing generator |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cur_upper | output | DATA_W | Current upper-panel base address for the DMA engine |
| cur_lower | output | DATA_W | Current lower-panel base address for the DMA engine |
| irq | output | 1 | Transfer interrupt (flag AND mask) |

## Verification
The hardest situations to reach are the collisions on a single clock edge: a pending write or a flag clear landing on the same edge as a frame-boundary transfer, and further writes made while `vsync` is still held high after its edge. The bench drives the bus strobe and `vsync` on the same falling edge, so both are seen by the same rising edge. It then reads the current address and `irq` before any later transfer can hide the outcome, and after that issues one more sync pulse to show that the delayed write value arrives.

// File: rtl/fbase_pkg.sv
package fbase_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned NPANEL = 2;

  localparam int unsigned OFF_PEND_UP = 32'h10;
  localparam int unsigned OFF_PEND_LO = 32'h14;
  localparam int unsigned OFF_MASK    = 32'h18;
  localparam int unsigned OFF_STAT    = 32'h1C;
  localparam int unsigned OFF_CLR     = 32'h20;
  localparam int unsigned OFF_CUR_UP  = 32'h24;
  localparam int unsigned OFF_CUR_LO  = 32'h28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND_UP,
    SEL_PEND_LO,
    SEL_MASK,
    SEL_STAT,
    SEL_CLR,
    SEL_CUR_UP,
    SEL_CUR_LO
  } reg_sel_e;

  function automatic reg_sel_e pend_slot(input int p);
    return (p == 0) ? SEL_PEND_UP : SEL_PEND_LO;
  endfunction

  function automatic reg_sel_e cur_slot(input int p);
    return (p == 0) ? SEL_CUR_UP : SEL_CUR_LO;
  endfunction
endpackage

// File: rtl/fbase_decode.sv
module fbase_decode
  import fbase_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    if (addr == ADDR_W'(OFF_PEND_UP))      sel = SEL_PEND_UP;
    else if (addr == ADDR_W'(OFF_PEND_LO)) sel = SEL_PEND_LO;
    else if (addr == ADDR_W'(OFF_MASK))    sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_STAT))    sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_CLR))     sel = SEL_CLR;
    else if (addr == ADDR_W'(OFF_CUR_UP))  sel = SEL_CUR_UP;
    else if (addr == ADDR_W'(OFF_CUR_LO))  sel = SEL_CUR_LO;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/fbase_bank.sv
module fbase_bank
  import fbase_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  reg_sel_e                      sel,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NPANEL-1:0][DATA_W-1:0] cur,
  input  logic                          flag,
  output logic [NPANEL-1:0][DATA_W-1:0] pend,
  output logic                          mask,
  output logic                          clr_pulse,
  output logic [DATA_W-1:0]             rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [DATA_W-1:0] LOW_MASK  = DATA_W'((64'd1 << ALIGN_BITS) - 64'd1);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~LOW_MASK;

  logic [DATA_W-1:0] rd_d;

  // pending base registers, one per panel
  for (genvar p = 0; p < NPANEL; p++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)
        pend[p] <= '0;
      else if (wr_en && sel == pend_slot(p))
        pend[p] <= wdata & KEEP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask <= 1'b0;
    else if (wr_en && sel == SEL_MASK)
      mask <= wdata[0];
  end

  assign clr_pulse = wr_en && (sel == SEL_CLR) && wdata[0];

  always_comb begin
    rd_d = '0;
    for (int p = 0; p < NPANEL; p++) begin
      if (sel == pend_slot(p)) rd_d = pend[p];
      if (sel == cur_slot(p))  rd_d = cur[p];
    end
    if (sel == SEL_MASK) rd_d = {{(DATA_W-1){1'b0}}, mask};
    if (sel == SEL_STAT) rd_d = {{(DATA_W-1){1'b0}}, flag};
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_d;
  end
endmodule

// File: rtl/fbase_shadow.sv
module fbase_shadow
  import fbase_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int LOAD_ON_ENABLE = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ctrl_en,
  input  logic                          vsync,
  input  logic [NPANEL-1:0][DATA_W-1:0] pend,
  output logic [NPANEL-1:0][DATA_W-1:0] cur,
  output logic                          xfer
);
  timeunit 1ns;
  timeprecision 1ps;

  logic vs_q;
  logic vs_edge;

  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b0;
    else     vs_q <= vsync;
  end

  assign vs_edge = vsync & ~vs_q;

  if (LOAD_ON_ENABLE != 0) begin : g_load_en
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= ctrl_en;
    end
    assign xfer = ctrl_en & (vs_edge | ~en_q);
  end else begin : g_vs_only
    assign xfer = ctrl_en & vs_edge;
  end

  // current registers read by the DMA engine
  for (genvar p = 0; p < NPANEL; p++) begin : g_cur
    always_ff @(posedge clk) begin
      if (rst)       cur[p] <= '0;
      else if (xfer) cur[p] <= pend[p];
    end
  end
endmodule

// File: rtl/fbase_status.sv
module fbase_status (
  input  logic clk,
  input  logic rst,
  input  logic xfer,
  input  logic clr,
  input  logic mask,
  output logic flag,
  output logic irq
);
  timeunit 1ns;
  timeprecision 1ps;

  // a transfer wins over a clear on the same edge
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (xfer) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  assign irq = flag & mask;
endmodule

// File: rtl/fbase_shadow_regs.sv
module fbase_shadow_regs
  import fbase_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 8,
  parameter int ALIGN_BITS     = 2,
  parameter int LOAD_ON_ENABLE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              vsync,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] cur_upper,
  output logic [DATA_W-1:0] cur_lower,
  output logic              irq
);
  timeunit 1ns;
  timeprecision 1ps;

  reg_sel_e                      sel;
  logic                          wr_en;
  logic                          rd_en;
  logic [NPANEL-1:0][DATA_W-1:0] pend;
  logic [NPANEL-1:0][DATA_W-1:0] cur;
  logic                          mask;
  logic                          flag;
  logic                          clr_pulse;
  logic                          xfer;

  assign wr_en = bus_sel & bus_we;
  assign rd_en = bus_sel & ~bus_we;

  fbase_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  fbase_bank #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .sel       (sel),
    .wdata     (bus_wdata),
    .cur       (cur),
    .flag      (flag),
    .pend      (pend),
    .mask      (mask),
    .clr_pulse (clr_pulse),
    .rdata     (bus_rdata)
  );

  fbase_shadow #(.DATA_W(DATA_W), .LOAD_ON_ENABLE(LOAD_ON_ENABLE)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .ctrl_en (ctrl_en),
    .vsync   (vsync),
    .pend    (pend),
    .cur     (cur),
    .xfer    (xfer)
  );

  fbase_status u_stat (
    .clk  (clk),
    .rst  (rst),
    .xfer (xfer),
    .clr  (clr_pulse),
    .mask (mask),
    .flag (flag),
    .irq  (irq)
  );

  assign cur_upper = cur[0];
  assign cur_lower = cur[1];
endmodule

// File: rtl/fbase_checker.sv
module fbase_checker
  import fbase_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int LOAD_ON_ENABLE = 1
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ctrl_en,
  input logic                          vsync,
  input logic                          irq,
  input logic [NPANEL-1:0][DATA_W-1:0] pend,
  input logic [NPANEL-1:0][DATA_W-1:0] cur,
  input logic                          flag,
  input logic                          mask,
  input logic                          clr
);
  timeunit 1ns;
  timeprecision 1ps;

  logic vs_seen;
  logic en_seen;
  logic evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_seen <= 1'b0;
      en_seen <= 1'b0;
    end else begin
      vs_seen <= vsync;
      en_seen <= ctrl_en;
    end
  end

  assign evt = ctrl_en && ((vsync && !vs_seen) || (LOAD_ON_ENABLE != 0 && !en_seen));

  // R3 / R9: a transfer copies the pending values held before the edge
  assert_copy_R3: assert property (@(posedge clk) disable iff (rst)
    evt |=> (cur == $past(pend)));

  // R4 / R5: no transfer, no change of the current registers
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(cur));

  // R7 / R10: the flag is set after every transfer, clear or not
  assert_flag_R7: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag);

  // R7: a clear without a transfer drops the flag
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt) |=> !flag);

  // R8: right after a transfer the interrupt follows the mask
  assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
    evt |=> (irq == mask));
endmodule

bind fbase_shadow_regs fbase_checker #(
  .DATA_W         (DATA_W),
  .LOAD_ON_ENABLE (LOAD_ON_ENABLE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl_en (ctrl_en),
  .vsync   (vsync),
  .irq     (irq),
  .pend    (pend),
  .cur     (cur),
  .flag    (flag),
  .mask    (mask),
  .clr     (clr_pulse)
);

// File: tb/sim_fbase_shadow_regs.sv
module sim_fbase_shadow_regs;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_VS = 2'd2;
  localparam logic [1:0] OP_EN = 2'd3;
  localparam int NVEC = 26;

  // {req, op, addr, data, expected}
  localparam logic [77:0] VEC [0:NVEC-1] = '{
    {4'd1,  OP_RD, 8'h10, 32'h0,         32'h0},         // R1 reset value
    {4'd2,  OP_WR, 8'h10, 32'h1000_0003, 32'h0},         // R2
    {4'd2,  OP_WR, 8'h14, 32'h2000_0002, 32'h0},         // R2
    {4'd2,  OP_RD, 8'h10, 32'h0,         32'h1000_0000}, // R2 low bits dropped
    {4'd2,  OP_RD, 8'h14, 32'h0,         32'h2000_0000}, // R2
    {4'd4,  OP_RD, 8'h24, 32'h0,         32'h0},         // R4 not yet loaded
    {4'd5,  OP_VS, 8'h00, 32'h0,         32'h0},         // R5 sync while disabled
    {4'd5,  OP_RD, 8'h24, 32'h0,         32'h0},         // R5
    {4'd5,  OP_RD, 8'h1C, 32'h0,         32'h0},         // R5 no flag
    {4'd6,  OP_EN, 8'h00, 32'h1,         32'h0},         // R6 enable load
    {4'd6,  OP_RD, 8'h24, 32'h0,         32'h1000_0000}, // R6
    {4'd6,  OP_RD, 8'h28, 32'h0,         32'h2000_0000}, // R6
    {4'd7,  OP_RD, 8'h1C, 32'h0,         32'h1},         // R7 flag set
    {4'd7,  OP_WR, 8'h20, 32'h1,         32'h0},         // R7 clear
    {4'd7,  OP_RD, 8'h1C, 32'h0,         32'h0},         // R7
    {4'd4,  OP_WR, 8'h10, 32'h3000_0000, 32'h0},         // R4 mid-frame write
    {4'd4,  OP_RD, 8'h24, 32'h0,         32'h1000_0000}, // R4 unchanged
    {4'd3,  OP_VS, 8'h00, 32'h0,         32'h0},         // R3
    {4'd3,  OP_RD, 8'h24, 32'h0,         32'h3000_0000}, // R3
    {4'd3,  OP_RD, 8'h28, 32'h0,         32'h2000_0000}, // R3
    {4'd7,  OP_RD, 8'h1C, 32'h0,         32'h1},         // R7
    {4'd8,  OP_WR, 8'h18, 32'h1,         32'h0},         // R8 mask on
    {4'd8,  OP_RD, 8'h18, 32'h0,         32'h1},         // R8
    {4'd7,  OP_RD, 8'h20, 32'h0,         32'h0},         // R7 clear reads zero
    {4'd4,  OP_WR, 8'h24, 32'hFFFF_FFFC, 32'h0},         // R4 write to current
    {4'd11, OP_RD, 8'h40, 32'h0,         32'h0}          // R11 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_en = 1'b0;
  logic        vsync = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] cur_upper;
  logic [31:0] cur_lower;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  fbase_shadow_regs u0 (
    .clk       (clk),
    .rst       (rst),
    .ctrl_en   (ctrl_en),
    .vsync     (vsync),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cur_upper (cur_upper),
    .cur_lower (cur_lower),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic vs_pulse();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cur_upper", cur_upper, 32'h0);
    chk("R1 cur_lower", cur_lower, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  req;
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      {req, op, a, d, e} = VEC[i];
      case (op)
        OP_WR: wr(a, d);
        OP_VS: vs_pulse();
        OP_EN: begin @(negedge clk); ctrl_en = d[0]; end
        default: begin
          rd(a, rv);
          chk($sformatf("R%0d vector %0d", req, i), rv, e);
        end
      endcase
    end

    // R8: flag and mask both set
    @(negedge clk);
    chk("R8 irq on", {31'h0, irq}, 32'h1);
    wr(8'h20, 32'h1);
    chk("R7 irq after clear", {31'h0, irq}, 32'h0);

    // R9: pending write on the same edge as a transfer
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h4000_0000;
    vsync = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; vsync = 1'b0;
    chk("R9 old value taken", cur_upper, 32'h3000_0000);
    chk("R8 irq after transfer", {31'h0, irq}, 32'h1);
    vs_pulse();
    chk("R9 new value next sync", cur_upper, 32'h4000_0000);

    // R10: clear on the same edge as a transfer
    wr(8'h10, 32'h5000_0000);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
    vsync = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; vsync = 1'b0;
    chk("R10 irq kept", {31'h0, irq}, 32'h1);
    chk("R3 cur_upper", cur_upper, 32'h5000_0000);
    rd(8'h1C, rv);
    chk("R10 status", rv, 32'h1);

    // R3: vsync held high transfers once
    wr(8'h10, 32'h6000_0000);
    wr(8'h20, 32'h1);
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    chk("R3 first edge", cur_upper, 32'h6000_0000);
    wr(8'h10, 32'h7000_0000);
    wr(8'h20, 32'h1);
    @(negedge clk);
    chk("R3 held high no reload", cur_upper, 32'h6000_0000);
    chk("R3 held high no flag", {31'h0, irq}, 32'h0);
    vsync = 1'b0;
    vs_pulse();
    chk("R3 next pulse", cur_upper, 32'h7000_0000);

    // R5 then R6: disable, then re-enable
    @(negedge clk);
    ctrl_en = 1'b0;
    wr(8'h10, 32'h8000_0000);
    vs_pulse();
    chk("R5 disabled sync", cur_upper, 32'h7000_0000);
    @(negedge clk);
    ctrl_en = 1'b1;
    @(negedge clk);
    chk("R6 enable reload", cur_upper, 32'h8000_0000);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run cur_upper", cur_upper, 32'h0);
    chk("R1 mid-run cur_lower", cur_lower, 32'h0);
    chk("R1 mid-run irq", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    rd(8'h14, rv);
    chk("R1 lower pending", rv, 32'h0);
    rd(8'h18, rv);
    chk("R1 mask", rv, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule